// File: doc/BRIEF.md
# Compare-Match Timer with Output Pins

This block is an up-counter with a selectable count rate and four compare registers, A to D. Each compare register raises its own one-cycle match flag when the counter meets it. Compare A can also send the counter back to zero, which turns the free-running count into a period set by software. Compares C and D each drive an output pin.

Each output pin starts at a programmed level. It keeps that level until its channel sees its first match. From then on, every match on that channel applies the action chosen by the channel's control field: hold, force low, force high or toggle.

The counter can count every clock, count once per 2, 4 or 8 clocks through a free-running prescaler, or count rising edges of an external event input. The control fields are plain input ports, and the design reads them every cycle.

Top module: `match_timer`

## Requirements
- R1: While `rst` is high, and on the first clock after it falls, `count` is 0, all `match` bits are 0 and both pins are 0.
- R2: With `clk_sel` = 000 the counter advances by one on every clock edge. Without a clear, it wraps from its all-ones value to 0.
- R3: With `clk_sel` = 001, 010 or 011 the counter advances once every 2, 4 or 8 clocks respectively. The prescaler runs freely, so any window of 2^k·n clocks adds exactly n.
- R4: With `clk_sel[2]` = 1 the counter counts rising edges of `ext_evt`, whatever the two lower bits are. The input passes through two flip-flops. A rise driven before edge 1 shows in `count` after edge 3. A level held high counts once, and the count moves by at most one per clock.
- R5: `match` bit i (A=0, B=1, C=2, D=3) is high for the one cycle after a counting edge at which `count` equalled compare i.
- R6: With `clr_on_a` = 1, the counting edge at which `count` equals `cmp_a` loads 0. With `clr_on_a` = 0 that edge loads `cmp_a`+1.
- R7: Before its first match, each pin shows its initial-level input, registered with one clock of latency.
- R8: On each match of its channel, a pin applies the action in the low two bits of its control field: 00 hold, 01 drive 0, 10 drive 1, 11 toggle. Bit 2 of the field is ignored.
- R9: After a channel's first match, its initial-level input no longer affects the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_on_a | input | 1 | Clear counter on compare A match |
| clk_sel | input | 3 | Count source select |
| init_lvl_c | input | 1 | Level of pin C before its first match |
| init_lvl_d | input | 1 | Level of pin D before its first match |
| ioctl_c | input | 3 | Match action for pin C (low two bits used) |
| ioctl_d | input | 3 | Match action for pin D (low two bits used) |
| cmp_a | input | W | Compare value A |
| cmp_b | input | W | Compare value B |
| cmp_c | input | W | Compare value C |
| cmp_d | input | W | Compare value D |
| ext_evt | input | 1 | External event input |
| count | output | W | Counter value |
| match | output | 4 | Match flags, bit 0 = A to bit 3 = D |
| pin_c | output | 1 | Output pin C |
| pin_d | output | 1 | Output pin D |

## Verification
The bench builds the timer with W = 8. This brings the natural wrap from 255 to 0 within a few hundred clocks, while the compare-A clear keeps the period at 31 counts. All four match actions, and repeated toggles on both pins, can therefore be seen in short runs. Divider ratios are measured over windows that are multiples of the divide factor, so the prescaler phase at the switch does not matter. The external input is checked for its three-edge latency, for a level held high and for pulses one clock wide.

// File: rtl/match_timer_pkg.sv
package match_timer_pkg;

  typedef enum logic [1:0] {
    ACT_HOLD   = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_TOGGLE = 2'b11
  } pin_act_e;

  localparam int NUM_CMP = 4;
  localparam int NUM_PIN = 2;
  localparam int SEL_W   = 3;

  function automatic logic apply_act(input pin_act_e act, input logic cur);
    case (act)
      ACT_HOLD:   return cur;
      ACT_LOW:    return 1'b0;
      ACT_HIGH:   return 1'b1;
      default:    return ~cur;
    endcase
  endfunction

endpackage

// File: rtl/mt_tick_gen.sv
module mt_tick_gen
  import match_timer_pkg::*;
#(
  parameter int PRE_W  = 3,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] clk_sel,
  input  logic             ext_evt,
  output logic             tick
);

  localparam int SH_W = SYNC_N + 1;

  logic [PRE_W-1:0] pre_q;
  logic [SH_W-1:0]  sync_q;
  logic [PRE_W-1:0] mask;
  logic             div_tick;
  logic             ext_rise;

  always_ff @(posedge clk) begin
    if (rst) pre_q <= '0;
    else     pre_q <= pre_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SH_W-2:0], ext_evt};
  end

  assign ext_rise = sync_q[SH_W-2] & ~sync_q[SH_W-1];

  always_comb begin
    mask = '0;
    for (int b = 0; b < PRE_W; b++) begin
      if (b < int'(clk_sel[1:0])) mask[b] = 1'b1;
    end
  end

  assign div_tick = ((pre_q & mask) == mask);
  assign tick     = clk_sel[2] ? ext_rise : div_tick;

endmodule

// File: rtl/mt_counter.sv
module mt_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         clr_hit,
  output logic [W-1:0] count
);

  always_ff @(posedge clk) begin
    if (rst)          count <= '0;
    else if (clr_hit) count <= '0;
    else if (tick)    count <= count + 1'b1;
  end

endmodule

// File: rtl/mt_out_chan.sv
module mt_out_chan
  import match_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       hit,
  input  logic       init_lvl,
  input  logic [2:0] ioctl,
  output logic       pin,
  output logic       done
);

  pin_act_e act;
  assign act = pin_act_e'(ioctl[1:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      pin  <= 1'b0;
      done <= 1'b0;
    end else if (hit) begin
      pin  <= apply_act(act, pin);
      done <= 1'b1;
    end else if (!done) begin
      pin  <= init_lvl;
    end
  end

endmodule

// File: rtl/match_timer.sv
module match_timer
  import match_timer_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_on_a,
  input  logic [2:0]   clk_sel,
  input  logic         init_lvl_c,
  input  logic         init_lvl_d,
  input  logic [2:0]   ioctl_c,
  input  logic [2:0]   ioctl_d,
  input  logic [W-1:0] cmp_a,
  input  logic [W-1:0] cmp_b,
  input  logic [W-1:0] cmp_c,
  input  logic [W-1:0] cmp_d,
  input  logic         ext_evt,
  output logic [W-1:0] count,
  output logic [3:0]   match,
  output logic         pin_c,
  output logic         pin_d
);

  localparam int PRE_W = 3;
  localparam int PIN_BASE = NUM_CMP - NUM_PIN;

  logic                 tick;
  logic [W-1:0]         cmp_v [NUM_CMP];
  logic [NUM_CMP-1:0]   hit;
  logic [NUM_PIN-1:0]   pin_v;
  logic [NUM_PIN-1:0]   chan_done;
  logic [NUM_PIN-1:0]   init_v;
  logic [2:0]           ioc_v [NUM_PIN];

  assign cmp_v[0] = cmp_a;
  assign cmp_v[1] = cmp_b;
  assign cmp_v[2] = cmp_c;
  assign cmp_v[3] = cmp_d;
  assign init_v   = {init_lvl_d, init_lvl_c};
  assign ioc_v[0] = ioctl_c;
  assign ioc_v[1] = ioctl_d;

  mt_tick_gen #(.PRE_W(PRE_W), .SYNC_N(2)) u_tick (
    .clk     (clk),
    .rst     (rst),
    .clk_sel (clk_sel),
    .ext_evt (ext_evt),
    .tick    (tick)
  );

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
    assign hit[i] = tick && (count == cmp_v[i]);
  end

  mt_counter #(.W(W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .clr_hit (hit[0] & clr_on_a),
    .count   (count)
  );

  always_ff @(posedge clk) begin
    if (rst) match <= '0;
    else     match <= hit;
  end

  for (genvar k = 0; k < NUM_PIN; k++) begin : g_pin
    mt_out_chan u_chan (
      .clk      (clk),
      .rst      (rst),
      .hit      (hit[PIN_BASE+k]),
      .init_lvl (init_v[k]),
      .ioctl    (ioc_v[k]),
      .pin      (pin_v[k]),
      .done     (chan_done[k])
    );
  end

  assign pin_c = pin_v[0];
  assign pin_d = pin_v[1];

endmodule

// File: rtl/mt_checker.sv
module mt_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         clr_on_a,
  input logic [W-1:0] cmp_d,
  input logic [W-1:0] count,
  input logic [3:0]   match,
  input logic         pin_c,
  input logic         pin_d,
  input logic [1:0]   chan_done
);

  logic seen_edge = 1'b0;
  always_ff @(posedge clk) seen_edge <= 1'b1;

  // R1
  a_r1_reset_state: assert property (@(posedge clk)
    (seen_edge && $past(rst)) |-> (count == '0 && match == 4'b0 && !pin_c && !pin_d));

  // R2 / R3 / R4: the counter moves by at most one step, or returns to zero
  a_r2_single_step: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (count == $past(count) || count == W'($past(count) + 1'b1) || count == '0));

  // R6
  a_r6_clear_on_a: assert property (@(posedge clk) disable iff (rst)
    ($past(clr_on_a) && match[0]) |-> (count == '0));

  // R5
  a_r5_match_d_value: assert property (@(posedge clk) disable iff (rst)
    match[3] |-> ($past(count) == $past(cmp_d)));

  // R9
  a_r9_pin_c_stable: assert property (@(posedge clk) disable iff (rst)
    (chan_done[0] && $past(chan_done[0]) && !match[2]) |-> $stable(pin_c));

  // R9
  a_r9_pin_d_stable: assert property (@(posedge clk) disable iff (rst)
    (chan_done[1] && $past(chan_done[1]) && !match[3]) |-> $stable(pin_d));

endmodule

bind match_timer mt_checker #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .clr_on_a  (clr_on_a),
  .cmp_d     (cmp_d),
  .count     (count),
  .match     (match),
  .pin_c     (pin_c),
  .pin_d     (pin_d),
  .chan_done (chan_done)
);

// File: tb/sim_match_timer.sv
module sim_match_timer;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         clr_on_a = 1'b0;
  logic [2:0]   clk_sel = 3'b000;
  logic         init_lvl_c = 1'b0, init_lvl_d = 1'b0;
  logic [2:0]   ioctl_c = 3'b000, ioctl_d = 3'b000;
  logic [W-1:0] cmp_a = '0, cmp_b = '0, cmp_c = '0, cmp_d = '0;
  logic         ext_evt = 1'b0;
  logic [W-1:0] count;
  logic [3:0]   match;
  logic         pin_c, pin_d;

  int checks = 0;
  int errors = 0;
  bit done_run = 1'b0;

  always #2 clk = ~clk;

  match_timer #(.W(W)) u0 (
    .clk(clk), .rst(rst), .clr_on_a(clr_on_a), .clk_sel(clk_sel),
    .init_lvl_c(init_lvl_c), .init_lvl_d(init_lvl_d),
    .ioctl_c(ioctl_c), .ioctl_d(ioctl_d),
    .cmp_a(cmp_a), .cmp_b(cmp_b), .cmp_c(cmp_c), .cmp_d(cmp_d),
    .ext_evt(ext_evt), .count(count), .match(match),
    .pin_c(pin_c), .pin_d(pin_d)
  );

  // divider vectors: select, window in clocks, expected count increase (R2, R3)
  localparam logic [2:0] T_SEL [0:5] = '{3'b000, 3'b001, 3'b010, 3'b011, 3'b001, 3'b011};
  localparam int         T_CYC [0:5] = '{10, 16, 16, 16, 6, 24};
  localparam int         T_INC [0:5] = '{10, 8, 4, 2, 3, 3};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_count(input int v);
    for (int i = 0; i < 600 && int'(count) != v; i++) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_run) begin
      errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int c0;
    clr_on_a = 1'b1; cmp_a = 8'd30; cmp_b = 8'd5; cmp_c = 8'd20; cmp_d = 8'd7;
    init_lvl_c = 1'b1; init_lvl_d = 1'b0;
    ioctl_c = 3'b101; ioctl_d = 3'b010;
    step(4);
    // R1: state held in reset
    chk("R1 count", int'(count), 0);
    chk("R1 match", int'(match), 0);
    chk("R1 pins", int'({pin_c, pin_d}), 0);
    rst = 1'b0;
    step(1);
    chk("R2 first count", int'(count), 1);
    chk("R7 pin_c init", int'(pin_c), 1);
    chk("R7 pin_d init", int'(pin_d), 0);

    wait_count(5); step(1);
    chk("R5 match B", int'(match), 4'b0010);
    chk("R5 count after B", int'(count), 6);
    step(1);
    chk("R5 match B one cycle", int'(match), 0);

    wait_count(7); step(1);
    chk("R8 pin_d drive1", int'(pin_d), 1);
    chk("R5 match D", int'(match), 4'b1000);

    wait_count(20);
    chk("R7 pin_c before match", int'(pin_c), 1);
    step(1);
    chk("R8 pin_c drive0 bit2 ignored", int'(pin_c), 0);

    wait_count(30); step(1);
    chk("R6 clear on A", int'(count), 0);
    chk("R5 match A", int'(match), 4'b0001);

    init_lvl_c = 1'b0; step(3); init_lvl_c = 1'b1; step(3);
    chk("R9 init ignored", int'(pin_c), 0);

    ioctl_c = 3'b011;
    wait_count(20); step(1);
    chk("R8 pin_c toggle", int'(pin_c), 1);

    ioctl_d = 3'b000;
    wait_count(7); step(1);
    chk("R8 pin_d hold", int'(pin_d), 1);
    ioctl_d = 3'b111;
    wait_count(7); step(1);
    chk("R8 pin_d toggle", int'(pin_d), 0);
    wait_count(7); step(1);
    chk("R8 pin_d toggle again", int'(pin_d), 1);

    clr_on_a = 1'b0;
    wait_count(30); step(1);
    chk("R6 no clear", int'(count), 31);
    wait_count(255); step(1);
    chk("R2 wrap", int'(count), 0);

    for (int t = 0; t < 6; t++) begin
      clk_sel = T_SEL[t];
      c0 = int'(count);
      step(T_CYC[t]);
      chk($sformatf("R3 divider sel %0d", T_SEL[t]), (int'(count) - c0 + 256) % 256, T_INC[t]);
    end

    // R4: external event source
    clk_sel = 3'b110;
    step(4);
    c0 = int'(count);
    ext_evt = 1'b1;
    step(2);
    chk("R4 latency not yet", int'(count), c0);
    step(1);
    chk("R4 latency counted", int'(count), (c0 + 1) % 256);
    step(6);
    chk("R4 held level counts once", int'(count), (c0 + 1) % 256);
    ext_evt = 1'b0; step(3);
    c0 = int'(count);
    for (int p = 0; p < 5; p++) begin
      ext_evt = 1'b1; step(3); ext_evt = 1'b0; step(3);
    end
    step(4);
    chk("R4 slow pulses", (int'(count) - c0 + 256) % 256, 5);
    clk_sel = 3'b100;
    c0 = int'(count);
    for (int p = 0; p < 4; p++) begin
      ext_evt = 1'b1; step(1); ext_evt = 1'b0; step(1);
    end
    step(4);
    chk("R4 narrow pulses", (int'(count) - c0 + 256) % 256, 4);

    rst = 1'b1; step(2);
    chk("R1 reset again", int'({count, match, pin_c, pin_d}), 0);

    done_run = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule